// File: doc/BRIEF.md
# Pin-Addressed GPIO Port Controller

This block owns the pad control for four 32-bit I/O ports, 128 pins in all. Each port keeps a direction register and an output register. Software-style whole-word access goes through a small register interface that stores or reads 32 bits at once. A pin-command interface addresses a single pin by its 7-bit number and moves it between three pin states: RELEASED (direction 0, output 0), DRIVEN_HIGH (direction 1, output 1) and DRIVEN_LOW (direction 1, output 0). The SET transition enters DRIVEN_HIGH, the CLEAR transition enters DRIVEN_LOW and the OFF transition enters RELEASED, from any state. A whole-register write can place a pin in any of the four direction/output combinations.

The pads receive an output-enable vector equal to the direction bits and an output-value vector that carries the output bit while enabled and 0 otherwise; the pad ring turns a disabled pin into high impedance. Pad inputs pass through a two-stage synchronizer into per-port input registers that the register interface can read.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset every direction and output bit is 0, so `pad_oe` and `pad_out` are all zero and every register reads 0.
- R2: A pin command with op 1 (SET) sets both the direction bit and the output bit of the addressed pin at the next clock edge.
- R3: A pin command with op 2 (CLEAR) sets the direction bit and clears the output bit of the addressed pin at the next clock edge, so the pad drives low.
- R4: A pin command with op 3 (OFF) clears both the direction bit and the output bit of the addressed pin at the next clock edge.
- R5: Pin number n selects port n/32 and bit n mod 32 with no reversal: pin 32 is port B bit 0 and pin 90 is port C bit 26 (mask 0x04000000).
- R6: `reg_addr` is {kind[1:0], port[1:0]} with kind 0 = output, 1 = direction, 2 = input, 3 = reserved. A write with kind 0 or 1 stores all 32 bits of `reg_wdata` at the next edge, bit k controlling pin 32*port+k; a write with kind 2 or 3 changes nothing.
- R7: `reg_rdata` returns, in the same cycle, the register named by `reg_addr`; the reserved kind reads 0.
- R8: `pad_oe` equals the direction bits and `pad_out` equals output AND direction, bit for bit.
- R9: A pad input value appears in its input register two clock edges after it is presented, and reading the register changes nothing.
- R10: When a pin command and a whole-register write hit the same port in one cycle, the addressed pin takes the pin command's result and all other bits take the written value.
- R11: A pin command with op 0 (NONE), or any op with `pin_cmd_valid` low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Whole-register write strobe |
| reg_addr | input | 4 | Register select {kind, port} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_cmd_valid | input | 1 | Pin command present this cycle |
| pin_cmd_op | input | 2 | 0 none, 1 set, 2 clear, 3 off |
| pin_cmd_num | input | 7 | Addressed pin number |
| pad_in | input | 128 | Raw pad input values |
| pad_oe | output | 128 | Pad output enables |
| pad_out | output | 128 | Pad output values |

## Verification
Pin commands are applied to the pins at port edges (0, 31, 32, 127) and to pin 90, which separates correct port/bit decoding from reversed or off-by-one mappings. Each command is issued from a different prior pin state so that CLEAR and OFF are told apart by the direction bit, and a no-op command checks that nothing moves. Whole-register writes use asymmetric patterns that expose swapped output/direction selects, and same-cycle collisions on one port and on different ports show whether the command is merged after the store. A changing pad-input pattern read one and two edges after it is presented checks the synchronizer depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int unsigned DEF_NUM_PORTS = 4;
    parameter int unsigned DEF_PORT_W    = 32;

    typedef enum logic [1:0] {
        PCMD_NONE     = 2'd0,
        PCMD_DRIVE_HI = 2'd1,
        PCMD_DRIVE_LO = 2'd2,
        PCMD_RELEASE  = 2'd3
    } pin_op_e;

    typedef enum logic [1:0] {
        RK_OUT  = 2'd0,
        RK_DIR  = 2'd1,
        RK_IN   = 2'd2,
        RK_RSVD = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_q   <= '0;
        end else begin
            stage1_q <= raw_in;
            sync_q   <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
#(
    parameter int unsigned PORT_W = 32,
    localparam int unsigned BIT_W = $clog2(PORT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_dir,
    input  logic [PORT_W-1:0] wdata,
    input  logic              cmd_hit,
    input  pin_op_e           cmd_op,
    input  logic [BIT_W-1:0]  cmd_bit,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q
);
    logic [PORT_W-1:0] out_n;
    logic [PORT_W-1:0] dir_n;

    // Word store first, then the pin command merged on top of it.
    always_comb begin
        out_n = wr_out ? wdata : out_q;
        dir_n = wr_dir ? wdata : dir_q;
        if (cmd_hit) begin
            unique case (cmd_op)
                PCMD_DRIVE_HI: begin
                    out_n[cmd_bit] = 1'b1;
                    dir_n[cmd_bit] = 1'b1;
                end
                PCMD_DRIVE_LO: begin
                    out_n[cmd_bit] = 1'b0;
                    dir_n[cmd_bit] = 1'b1;
                end
                PCMD_RELEASE: begin
                    out_n[cmd_bit] = 1'b0;
                    dir_n[cmd_bit] = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            out_q <= out_n;
            dir_q <= dir_n;
        end
    end

    // R2
    drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd_op == PCMD_DRIVE_HI) |=> (out_q[$past(cmd_bit)] && dir_q[$past(cmd_bit)]));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd_op == PCMD_RELEASE) |=> (!out_q[$past(cmd_bit)] && !dir_q[$past(cmd_bit)]));

    // R6
    dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir && !cmd_hit) |=> (dir_q == $past(wdata)));

    // R11
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_hit && !wr_out) |=> $stable(out_q));
endmodule

// File: rtl/gpio_reg_read.sv
module gpio_reg_read
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 32,
    localparam int unsigned TOTAL    = NUM_PORTS * PORT_W,
    localparam int unsigned PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [TOTAL-1:0]  out_flat,
    input  logic [TOTAL-1:0]  dir_flat,
    input  logic [TOTAL-1:0]  in_flat,
    input  reg_kind_e         kind,
    input  logic [PSEL_W-1:0] psel,
    output logic [PORT_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (int'(psel) < NUM_PORTS) begin
            unique case (kind)
                RK_OUT:  rdata = out_flat[psel*PORT_W +: PORT_W];
                RK_DIR:  rdata = dir_flat[psel*PORT_W +: PORT_W];
                RK_IN:   rdata = in_flat[psel*PORT_W +: PORT_W];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = gpio_pkg::DEF_NUM_PORTS,
    parameter int unsigned PORT_W    = gpio_pkg::DEF_PORT_W,
    localparam int unsigned TOTAL    = NUM_PORTS * PORT_W,
    localparam int unsigned BIT_W    = $clog2(PORT_W),
    localparam int unsigned PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int unsigned PIN_W    = $clog2(TOTAL),
    localparam int unsigned ADDR_W   = 2 + PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic              pin_cmd_valid,
    input  logic [1:0]        pin_cmd_op,
    input  logic [PIN_W-1:0]  pin_cmd_num,
    input  logic [TOTAL-1:0]  pad_in,
    output logic [TOTAL-1:0]  pad_oe,
    output logic [TOTAL-1:0]  pad_out
);
    reg_kind_e         kind;
    logic [PSEL_W-1:0] psel;
    pin_op_e           op;
    logic [BIT_W-1:0]  cmd_bit;
    logic [PIN_W-1:0]  cmd_port_wide;
    logic [TOTAL-1:0]  out_flat;
    logic [TOTAL-1:0]  dir_flat;
    logic [TOTAL-1:0]  in_flat;

    assign kind          = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
    assign psel          = reg_addr[PSEL_W-1:0];
    assign op            = pin_op_e'(pin_cmd_op);
    assign cmd_bit       = pin_cmd_num[BIT_W-1:0];
    assign cmd_port_wide = pin_cmd_num >> BIT_W;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        logic wr_o;
        logic wr_d;
        logic [PORT_W-1:0] oq;
        logic [PORT_W-1:0] dq;

        assign hit  = pin_cmd_valid && (op != PCMD_NONE) && (int'(cmd_port_wide) == p);
        assign wr_o = reg_wr && (kind == RK_OUT) && (int'(psel) == p);
        assign wr_d = reg_wr && (kind == RK_DIR) && (int'(psel) == p);

        gpio_port_bank #(.PORT_W(PORT_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_out  (wr_o),
            .wr_dir  (wr_d),
            .wdata   (reg_wdata),
            .cmd_hit (hit),
            .cmd_op  (op),
            .cmd_bit (cmd_bit),
            .out_q   (oq),
            .dir_q   (dq)
        );

        assign out_flat[p*PORT_W +: PORT_W] = oq;
        assign dir_flat[p*PORT_W +: PORT_W] = dq;
    end

    gpio_in_sync #(.W(TOTAL)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pad_in),
        .sync_q (in_flat)
    );

    gpio_reg_read #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_read (
        .out_flat (out_flat),
        .dir_flat (dir_flat),
        .in_flat  (in_flat),
        .kind     (kind),
        .psel     (psel),
        .rdata    (reg_rdata)
    );

    assign pad_oe  = dir_flat;
    assign pad_out = out_flat & dir_flat;

    // R3
    drive_lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd_valid && op == PCMD_DRIVE_LO)
            |=> (pad_oe[$past(pin_cmd_num)] && !pad_out[$past(pin_cmd_num)]));

    // R11
    no_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && (!pin_cmd_valid || op == PCMD_NONE)) |=> $stable(pad_oe));
endmodule

// File: tb/test_gpio_pin_ctrl.sv
`timescale 1ns/100ps
module test_gpio_pin_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         pin_cmd_valid = 1'b0;
    logic [1:0]   pin_cmd_op = '0;
    logic [6:0]   pin_cmd_num = '0;
    logic [127:0] pad_in = '0;
    logic [127:0] pad_oe;
    logic [127:0] pad_out;

    int errors = 0;
    int checks = 0;

    logic [127:0] m_out = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

    always #2 clk = ~clk;

    gpio_pin_ctrl i_gpio_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_cmd_valid(pin_cmd_valid), .pin_cmd_op(pin_cmd_op),
        .pin_cmd_num(pin_cmd_num), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_out[a[1:0]*32 +: 32];
            2'd1: return m_dir[a[1:0]*32 +: 32];
            2'd2: return m_s2[a[1:0]*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    // One clock: model the edge from the inputs present now, then compare pads.
    task automatic step();
        logic [127:0] no, nd, cap;
        no = m_out; nd = m_dir; cap = pad_in;
        if (reg_wr) begin
            if (reg_addr[3:2] == 2'd0) no[reg_addr[1:0]*32 +: 32] = reg_wdata;
            if (reg_addr[3:2] == 2'd1) nd[reg_addr[1:0]*32 +: 32] = reg_wdata;
        end
        if (pin_cmd_valid) begin
            case (pin_cmd_op)
                2'd1: begin no[pin_cmd_num] = 1'b1; nd[pin_cmd_num] = 1'b1; end
                2'd2: begin no[pin_cmd_num] = 1'b0; nd[pin_cmd_num] = 1'b1; end
                2'd3: begin no[pin_cmd_num] = 1'b0; nd[pin_cmd_num] = 1'b0; end
                default: ;
            endcase
        end
        @(posedge clk);
        if (rst_n) begin
            m_out = no; m_dir = nd; m_s2 = m_s1; m_s1 = cap;
        end
        #1;
        check("R8 pad_oe", pad_oe, m_dir);
        check("R8 pad_out", pad_out, m_out & m_dir);
        reg_wr = 1'b0;
        pin_cmd_valid = 1'b0;
        pin_cmd_op = 2'd0;
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        reg_addr = a;
        #0.2;
        check(req, {96'h0, reg_rdata}, {96'h0, model_rd(a)});
    endtask

    task automatic pin(input logic [1:0] op_i, input logic [6:0] n);
        pin_cmd_valid = 1'b1; pin_cmd_op = op_i; pin_cmd_num = n;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        check("R1 oe at reset", pad_oe, '0);
        check("R1 out at reset", pad_out, '0);
        rst_n = 1'b1;
        step();
        for (int a = 0; a < 16; a++) rd("R1 R7 reset read", 4'(a));

        // SET at port edges
        pin(2'd1, 7'd0);   step(); check("R2 pin0", {126'h0, pad_oe[0], pad_out[0]}, 128'h3);
        pin(2'd1, 7'd31);  step(); rd("R2 portA out", 4'h0);
        pin(2'd1, 7'd32);  step(); check("R5 pin32 port B bit0", {96'h0, model_rd(4'h1)}, 128'h1);
        rd("R5 portB out", 4'h1);
        pin(2'd1, 7'd90);  step(); rd("R5 portC out", 4'h2);
        reg_addr = 4'h2; #0.2; check("R5 pin90 mask", {96'h0, reg_rdata}, 128'h0400_0000);
        rd("R5 portC dir", 4'h6);
        pin(2'd1, 7'd127); step(); check("R2 pin127", {126'h0, pad_oe[127], pad_out[127]}, 128'h3);

        // CLEAR then OFF on pin 90
        pin(2'd2, 7'd90); step();
        check("R3 pin90 low", {126'h0, pad_oe[90], pad_out[90]}, 128'h2);
        rd("R3 portC dir", 4'h6); rd("R3 portC out", 4'h2);
        pin(2'd3, 7'd90); step();
        check("R4 pin90 off", {126'h0, pad_oe[90], pad_out[90]}, 128'h0);
        rd("R4 portC dir", 4'h6);
        pin(2'd2, 7'd5); step(); rd("R3 pin5 dir", 4'h4);

        // NONE op and invalid command
        pin(2'd0, 7'd0); step(); check("R11 none op", {127'h0, pad_out[0]}, 128'h1);
        pin_cmd_op = 2'd3; pin_cmd_num = 7'd0; step();
        check("R11 valid low", {127'h0, pad_oe[0]}, 128'h1);

        // Whole-register stores
        wr(4'h0, 32'hA5A5_0F0F); step(); rd("R6 out store", 4'h0);
        wr(4'h4, 32'hFFFF_0000); step(); rd("R6 dir store", 4'h4);
        check("R8 masked", {96'h0, pad_out[31:0]}, {96'h0, 32'hA5A5_0000});
        wr(4'h9, 32'hFFFF_FFFF); step(); rd("R6 input kind ignored", 4'h9);
        rd("R6 portB out unchanged", 4'h1); rd("R6 portB dir unchanged", 4'h5);
        wr(4'hD, 32'h1234_5678); step(); rd("R7 reserved reads 0", 4'hD);
        rd("R6 reserved write ignored", 4'h1);

        // Collisions
        wr(4'h3, 32'hFFFF_FFFF); pin(2'd3, 7'd100); step();
        rd("R10 same port out", 4'h3);
        reg_addr = 4'h3; #0.2; check("R10 out D", {96'h0, reg_rdata}, {96'h0, 32'hFFFF_FFEF});
        wr(4'h7, 32'h0000_00F0); pin(2'd1, 7'd101); step();
        reg_addr = 4'h7; #0.2; check("R10 dir D", {96'h0, reg_rdata}, {96'h0, 32'h0000_00F0});
        wr(4'h4, 32'h0); pin(2'd1, 7'd40); step();
        rd("R10 other port dir A", 4'h4); rd("R10 other port dir B", 4'h5);

        // Input synchronizer depth
        pad_in = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'h5555_AAAA};
        step(); rd("R9 one edge", 4'h8);
        reg_addr = 4'h8; #0.2; check("R9 not yet", {96'h0, reg_rdata}, 128'h0);
        step();
        reg_addr = 4'hB; #0.2; check("R9 two edges", {96'h0, reg_rdata}, {96'h0, 32'hDEAD_BEEF});
        rd("R9 repeat read", 4'hB); rd("R9 repeat read", 4'hB); rd("R9 port A", 4'h8);
        pad_in = '0;
        for (int i = 0; i < 4; i++) step();
        for (int a = 0; a < 16; a++) rd("R7 final sweep", 4'(a));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule